// File: doc/BRIEF.md
# Parallel Composition and Event-Hiding Combiner

This block sits one level up in a tree of hardware process blocks. It joins a number of child processes that run side by side, and it hides a chosen set of events from everything outside it. The children report whether they are ready to take a step. They also report which events they could accept in their present state. The combiner merges both kinds of report into what the parent sees. It also sends the parent's acknowledgement and start trigger back down to every child.

A hidden event is raised from inside the block, not from the environment. A hidden event fires when every child can accept it. It is ORed into the event bus that enters the first child, and the bus then runs from child to child. Hidden bits are cleared from the bus that leaves the block. Unanimous requests for events that are not hidden here go up to the parent, which may hide them at its own level. When two hidden events are both ready, both are raised together. The block does not arbitrate between them, so a child that cannot take both at once may deadlock.

The upward step request and the upward event requests can be taken from a register stage or straight from logic, chosen by a parameter. Registering them cuts the combinational path at each level of a deep tree.

Top module: `cmb_combiner`

## Requirements
- R1: With `REG_UP`=1, `sync_req` is high in the cycle after a rising clock edge at which every bit of `child_sync_req` was 1, and low after an edge at which any bit was 0.
- R2: Every bit of `child_sync_ack` equals `sync_ack`, and every bit of `child_trigger` equals `trigger`, in the same cycle.
- R3: A hidden event j is raised only when bit j of every child's request lane is 1. Child i's request lane is `child_ev_req[i*EV_W +: EV_W]`, and bit j of a lane is event j.
- R4: The bus into child 0, `child_ev_in[0 +: EV_W]`, equals `ev_in` ORed with the hidden events raised under R3, in the same cycle.
- R5: `ev_fwd` equals the last child's forward lane, `child_ev_fwd[(N_CHILD-1)*EV_W +: EV_W]`, with every bit set in `HIDE_MASK` cleared to 0.
- R6: For a bit not set in `HIDE_MASK`, `ev_req_up` is the AND of that bit over all child request lanes, registered like R1. For every bit set in `HIDE_MASK`, `ev_req_up` is 0.
- R7: For k ≥ 1, the input lane of child k equals the forward lane of child k-1.
- R8: If two or more hidden events have unanimous requests in the same cycle, all of them are 1 on the bus into child 0 together, with no priority between them.
- R9: While `rst_n` is low, `sync_req` and `ev_req_up` are 0 after each rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the upward register stage |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | EV_W | Event bus arriving from outside |
| ev_fwd | output | EV_W | Event bus forwarded onward, hidden bits cleared |
| child_ev_in | output | N_CHILD*EV_W | Event input lane for each child |
| child_ev_fwd | input | N_CHILD*EV_W | Event forward lane from each child |
| child_ev_req | input | N_CHILD*EV_W | Event request lane from each child |
| child_sync_req | input | N_CHILD | Per-child ready-to-step request |
| child_sync_ack | output | N_CHILD | Acknowledgement sent to each child |
| child_trigger | output | N_CHILD | Start trigger sent to each child |
| sync_req | output | 1 | Combined step request to the parent |
| sync_ack | input | 1 | Acknowledgement from the parent |
| trigger | input | 1 | Start trigger from the parent |
| ev_req_up | output | EV_W | Unanimous requests for events not hidden here |

## Verification
The bench builds the block with three children, an eight-bit event bus, a hide mask of 0x34 and the registered upward stage. Three children are enough to show a request held back by a single middle child, and to exercise a chain in which every forward lane feeds the next lane. The mask mixes hidden and visible bits in one byte. This lets one vector test filtering, merging and passing up side by side. It also puts two hidden events in reach, so the simultaneous raise that can cause deadlock is reproduced.

// File: rtl/cmb_pkg.sv
// Shared helpers for the composition/hiding combiner.
// Assumes child lanes are packed side by side, child 0 in the low bits.
package cmb_pkg;
    // Width of a bus that carries one lane per child.
    function automatic int unsigned bus_bits(input int unsigned n, input int unsigned w);
        return n * w;
    endfunction
endpackage

// File: rtl/cmb_unanimity.sv
// Per-bit AND across N lanes of width W: a bit is set only when every lane sets it.
// Assumes N >= 1; lane k occupies bits [k*W +: W].
module cmb_unanimity #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 32
) (
    input  logic [N*W-1:0] lanes,
    output logic [W-1:0]   all_set
);
    // Reduce all lanes into one unanimous vector.
    always_comb begin
        all_set = '1;
        for (int k = 0; k < N; k++) begin
            all_set = all_set & lanes[k*W +: W];
        end
    end
endmodule

// File: rtl/cmb_event_gate.sv
// Merges unanimously requested hidden events into the internal bus, removes
// hidden bits from the outgoing bus, and keeps only visible requests for the parent.
// Assumes HIDE_MASK marks the events hidden at this level.
module cmb_event_gate #(
    parameter int unsigned W         = 32,
    parameter logic [W-1:0] HIDE_MASK = '0
) (
    input  logic [W-1:0] ev_in,
    input  logic [W-1:0] all_req,
    input  logic [W-1:0] last_fwd,
    output logic [W-1:0] int_bus,
    output logic [W-1:0] ev_out,
    output logic [W-1:0] up_req
);
    // Merge, filter and split in one combinational step.
    always_comb begin
        int_bus = ev_in | (all_req & HIDE_MASK);
        ev_out  = last_fwd & ~HIDE_MASK;
        up_req  = all_req & ~HIDE_MASK;
    end
endmodule

// File: rtl/cmb_chain.sv
// Links the children into a chain: child 0 takes the internal bus and each
// later child takes its predecessor's forward lane. It also returns the last
// child's forward lane. Assumes N >= 1.
module cmb_chain #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   int_bus,
    input  logic [N*W-1:0] child_fwd,
    output logic [N*W-1:0] child_in,
    output logic [W-1:0]   last_fwd
);
    for (genvar k = 0; k < N; k++) begin : g_link
        if (k == 0) begin : g_head
            // Head of the chain sees the merged bus.
            assign child_in[0 +: W] = int_bus;
        end else begin : g_next
            // Each later child sees the previous child's forward lane.
            assign child_in[k*W +: W] = child_fwd[(k-1)*W +: W];
        end
    end

    // Tail of the chain leaves through the filter.
    assign last_fwd = child_fwd[(N-1)*W +: W];
endmodule

// File: rtl/cmb_up_stage.sv
// Upward path to the parent: the combined step request and the visible event
// requests, either registered (REG=1) or passed straight through (REG=0).
// Synchronous active-low reset clears the registers.
module cmb_up_stage #(
    parameter int unsigned W   = 32,
    parameter bit          REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_all,
    input  logic [W-1:0] req_all,
    output logic         sync_up,
    output logic [W-1:0] req_up
);
    if (REG) begin : g_reg
        // Register the upward signals to cut path depth per tree level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_up <= 1'b0;
                req_up  <= '0;
            end else begin
                sync_up <= sync_all;
                req_up  <= req_all;
            end
        end
    end else begin : g_comb
        // Pass the upward signals straight through.
        assign sync_up = sync_all;
        assign req_up  = req_all;
    end
endmodule

// File: rtl/cmb_combiner.sv
// Top of the composition/hiding combiner. It joins N_CHILD parallel children,
// raises hidden events on unanimous request, filters them from the forwarded
// bus, and reports step readiness and visible requests upward.
// Assumes child lanes are packed with child 0 in the low bits.
module cmb_combiner #(
    parameter int unsigned      N_CHILD   = 4,
    parameter int unsigned      EV_W      = 32,
    parameter logic [EV_W-1:0]  HIDE_MASK = 32'h0000_00F0,
    parameter bit               REG_UP    = 1'b1
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [EV_W-1:0]                               ev_in,
    output logic [EV_W-1:0]                               ev_fwd,
    output logic [cmb_pkg::bus_bits(N_CHILD, EV_W)-1:0]   child_ev_in,
    input  logic [cmb_pkg::bus_bits(N_CHILD, EV_W)-1:0]   child_ev_fwd,
    input  logic [cmb_pkg::bus_bits(N_CHILD, EV_W)-1:0]   child_ev_req,
    input  logic [N_CHILD-1:0]                            child_sync_req,
    output logic [N_CHILD-1:0]                            child_sync_ack,
    output logic [N_CHILD-1:0]                            child_trigger,
    output logic                                          sync_req,
    input  logic                                          sync_ack,
    input  logic                                          trigger,
    output logic [EV_W-1:0]                               ev_req_up
);
    logic [EV_W-1:0] all_req;
    logic            sync_all;
    logic [EV_W-1:0] int_bus;
    logic [EV_W-1:0] last_fwd;
    logic [EV_W-1:0] up_comb;

    // Unanimous event requests across children.
    cmb_unanimity #(.N(N_CHILD), .W(EV_W)) u_ev_and (
        .lanes   (child_ev_req),
        .all_set (all_req)
    );

    // Unanimous step readiness across children.
    cmb_unanimity #(.N(N_CHILD), .W(1)) u_sync_and (
        .lanes   (child_sync_req),
        .all_set (sync_all)
    );

    // Merge hidden events in, filter them out, split visible requests.
    cmb_event_gate #(.W(EV_W), .HIDE_MASK(HIDE_MASK)) u_gate (
        .ev_in    (ev_in),
        .all_req  (all_req),
        .last_fwd (last_fwd),
        .int_bus  (int_bus),
        .ev_out   (ev_fwd),
        .up_req   (up_comb)
    );

    // Child-to-child event chain.
    cmb_chain #(.N(N_CHILD), .W(EV_W)) u_chain (
        .int_bus   (int_bus),
        .child_fwd (child_ev_fwd),
        .child_in  (child_ev_in),
        .last_fwd  (last_fwd)
    );

    // Upward register or bypass stage.
    cmb_up_stage #(.W(EV_W), .REG(REG_UP)) u_up (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_all (sync_all),
        .req_all  (up_comb),
        .sync_up  (sync_req),
        .req_up   (ev_req_up)
    );

    // Broadcast of acknowledgement and trigger to every child.
    assign child_sync_ack = {N_CHILD{sync_ack}};
    assign child_trigger  = {N_CHILD{trigger}};
endmodule

// File: rtl/cmb_combiner_chk.sv
// Checker for cmb_combiner, attached by bind. It watches only the top-level
// ports and relates them over time.
module cmb_combiner_chk #(
    parameter int unsigned     N_CHILD   = 4,
    parameter int unsigned     EV_W      = 32,
    parameter logic [EV_W-1:0] HIDE_MASK = '0,
    parameter bit              REG_UP    = 1'b1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [EV_W-1:0]           ev_in,
    input logic [EV_W-1:0]           ev_fwd,
    input logic [N_CHILD*EV_W-1:0]   child_ev_in,
    input logic [N_CHILD*EV_W-1:0]   child_ev_fwd,
    input logic [N_CHILD-1:0]        child_sync_req,
    input logic [N_CHILD-1:0]        child_sync_ack,
    input logic [N_CHILD-1:0]        child_trigger,
    input logic                      sync_req,
    input logic                      sync_ack,
    input logic                      trigger,
    input logic [EV_W-1:0]           ev_req_up
);
    if (REG_UP) begin : g_reg_chk
        assert_sync_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (&child_sync_req) |=> sync_req);
        assert_sync_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(&child_sync_req) |=> !sync_req);
    end

    assert_ack_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(child_sync_ack) == (sync_ack ? N_CHILD : 0));
    assert_trig_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(child_trigger) == (trigger ? N_CHILD : 0));

    assert_merge_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (child_ev_in[0 +: EV_W] & ev_in) == ev_in);
    assert_merge_only_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((child_ev_in[0 +: EV_W] ^ ev_in) & ~HIDE_MASK) == '0);

    assert_fwd_filtered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fwd & HIDE_MASK) == '0);

    assert_up_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_req_up & HIDE_MASK) == '0);

    for (genvar k = 1; k < N_CHILD; k++) begin : g_chain_chk
        assert_chain_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
            child_ev_in[k*EV_W +: EV_W] == child_ev_fwd[(k-1)*EV_W +: EV_W]);
    end
endmodule

bind cmb_combiner cmb_combiner_chk #(
    .N_CHILD(N_CHILD), .EV_W(EV_W), .HIDE_MASK(HIDE_MASK), .REG_UP(REG_UP)
) u_cmb_chk (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .ev_fwd(ev_fwd),
    .child_ev_in(child_ev_in), .child_ev_fwd(child_ev_fwd),
    .child_sync_req(child_sync_req), .child_sync_ack(child_sync_ack),
    .child_trigger(child_trigger), .sync_req(sync_req), .sync_ack(sync_ack),
    .trigger(trigger), .ev_req_up(ev_req_up)
);

// File: tb/test_cmb_combiner.sv
module test_cmb_combiner;
    localparam int unsigned N  = 3;
    localparam int unsigned W  = 8;
    localparam logic [W-1:0] MASK = 8'h34;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]   ev_in = '0;
    logic [W-1:0]   ev_fwd;
    logic [N*W-1:0] child_ev_in;
    logic [N*W-1:0] child_ev_fwd = '0;
    logic [N*W-1:0] child_ev_req = '0;
    logic [N-1:0]   child_sync_req = '0;
    logic [N-1:0]   child_sync_ack;
    logic [N-1:0]   child_trigger;
    logic           sync_req;
    logic           sync_ack = 1'b0;
    logic           trigger = 1'b0;
    logic [W-1:0]   ev_req_up;

    always #10 clk = ~clk;   // 50 MHz

    cmb_combiner #(.N_CHILD(N), .EV_W(W), .HIDE_MASK(MASK), .REG_UP(1'b1)) i_cmb_combiner (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .ev_fwd(ev_fwd),
        .child_ev_in(child_ev_in), .child_ev_fwd(child_ev_fwd),
        .child_ev_req(child_ev_req), .child_sync_req(child_sync_req),
        .child_sync_ack(child_sync_ack), .child_trigger(child_trigger),
        .sync_req(sync_req), .sync_ack(sync_ack), .trigger(trigger),
        .ev_req_up(ev_req_up)
    );

    typedef struct {
        string          tag;
        logic           sreq;
        logic [W-1:0]   up;
        logic [W-1:0]   fwd;
        logic [N*W-1:0] cin;
        logic [N-1:0]   cack;
        logic [N-1:0]   ctrig;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: applies one vector at a falling edge and pushes its expectation.
    task automatic drive(input string tag, input logic [W-1:0] e_in,
                         input logic [N*W-1:0] c_fwd, input logic [N*W-1:0] c_req,
                         input logic [N-1:0] c_sync, input logic ack, input logic trg);
        exp_t x;
        logic [W-1:0] all;
        @(negedge clk);
        ev_in = e_in; child_ev_fwd = c_fwd; child_ev_req = c_req;
        child_sync_req = c_sync; sync_ack = ack; trigger = trg;
        all = '1;
        for (int k = 0; k < N; k++) all = all & c_req[k*W +: W];
        x.tag   = tag;
        x.sreq  = &c_sync;
        x.up    = all & ~MASK;
        x.fwd   = c_fwd[(N-1)*W +: W] & ~MASK;
        x.cin[0 +: W] = e_in | (all & MASK);
        for (int k = 1; k < N; k++) x.cin[k*W +: W] = c_fwd[(k-1)*W +: W];
        x.cack  = ack ? '1 : '0;
        x.ctrig = trg ? '1 : '0;
        sb.push_back(x);
    endtask

    // Monitor: after the edge that follows each vector, compares all outputs.
    always begin
        @(posedge clk);
        #5;
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            chk({"R1 sync_req ", x.tag}, 64'(sync_req), 64'(x.sreq));
            chk({"R6 ev_req_up ", x.tag}, 64'(ev_req_up), 64'(x.up));
            chk({"R5 ev_fwd ", x.tag}, 64'(ev_fwd), 64'(x.fwd));
            chk({"R4 R3 child0 bus ", x.tag}, 64'(child_ev_in[0 +: W]), 64'(x.cin[0 +: W]));
            chk({"R7 chain ", x.tag}, 64'(child_ev_in), 64'(x.cin));
            chk({"R2 ack ", x.tag}, 64'(child_sync_ack), 64'(x.cack));
            chk({"R2 trigger ", x.tag}, 64'(child_trigger), 64'(x.ctrig));
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset holds the upward outputs low even with unanimous requests.
        child_sync_req = '1;
        child_ev_req   = '1;
        repeat (2) @(posedge clk);
        #5;
        chk("R9 sync_req in reset", 64'(sync_req), 64'd0);
        chk("R9 ev_req_up in reset", 64'(ev_req_up), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive("idle", 8'h00, 24'h000000, 24'h000000, 3'b000, 1'b0, 1'b0);
        drive("all ready R1", 8'h00, 24'h000000, 24'h000000, 3'b111, 1'b0, 1'b0);
        drive("one missing R1", 8'h00, 24'h000000, 24'h000000, 3'b101, 1'b0, 1'b0);
        drive("ack only R2", 8'h00, 24'h000000, 24'h000000, 3'b000, 1'b1, 1'b0);
        drive("trigger only R2", 8'h00, 24'h000000, 24'h000000, 3'b000, 1'b0, 1'b1);
        // R3: hidden bit 2 requested by all children.
        drive("hidden 2 unanimous R3", 8'h01, 24'h000000, 24'h040404, 3'b000, 1'b0, 1'b0);
        // R3: hidden bit 4 missing from the middle child.
        drive("hidden 4 partial R3", 8'h00, 24'h000000, 24'h100010, 3'b000, 1'b0, 1'b0);
        // R8: hidden bits 2 and 5 raised together.
        drive("two hidden R8", 8'h00, 24'h000000, 24'h242424, 3'b000, 1'b0, 1'b0);
        // R6: visible bits 0 and 7 unanimous, bit 1 partial, hidden 4 unanimous.
        drive("visible up R6", 8'h00, 24'h919193, 24'h919391, 3'b111, 1'b1, 1'b1);
        // R5 R7: distinct forward lanes with hidden bits set.
        drive("filter R5", 8'hC3, 24'hFF5AA5, 24'h000000, 3'b011, 1'b0, 1'b0);
        drive("full bus R4", 8'hFF, 24'h34CB12, 24'hFFFFFF, 3'b111, 1'b1, 1'b0);
        drive("back to idle", 8'h00, 24'h000000, 24'h000000, 3'b000, 1'b0, 1'b0);

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule